// File: doc/BRIEF.md
# IPv4 Header Check and TTL Update

This block sits on a 32-bit word stream that carries one IPv4 datagram per frame. A frame is marked by a start strobe on its first word and an end strobe on its last word. A data-enable qualifies every word, and frames are expected to be well formed, with each start strobe eventually matched by an end strobe. The block checks each header as it arrives and decides the packet's fate in the same pass. It confirms the version is 4, that the header length in 32-bit words is legal, and that the one's-complement header sum is correct. It also tests whether the TTL would expire on this hop.

Packets that fail a check disappear completely. Packets whose TTL would expire also produce no words; instead a one-cycle `icmp_req` pulse tells the surrounding logic that a time-exceeded reply is needed. Every other packet is forwarded with its TTL lowered by one and its checksum adjusted incrementally. A start-of-payload strobe marks the first word after the variable-length header.

Internally, an input-side scanner (states SC_IDLE, SC_HDR, SC_BODY) computes one verdict per frame and pushes it into a small verdict queue. Accepted words go into a word FIFO. The output state machine has three states:
- OS_WAIT waits until both the word FIFO and the verdict queue hold an entry. It then pops the first word and moves on:
  - to OS_FWD when the verdict is forward;
  - to OS_DROP when the verdict is drop or expire;
  - or stays in OS_WAIT if that first word already ended the frame.
- OS_FWD and OS_DROP both return to OS_WAIT on the word that carries the end mark.

Top module: `ipv4_ttl_fwd`

## Requirements
- R1: A frame whose first word has a version field (bits 31:28) other than 4 produces no output words.
- R2: A frame whose header length field (bits 27:24 of the first word, in 32-bit words) is below 5 produces no output words; values 5 to 15 are accepted.
- R3: The 16-bit one's-complement sum of all halfwords of the header (header-length words) must fold to 0xFFFF; otherwise the frame produces no output words.
- R4: In every forwarded frame, the TTL byte (bits 31:24 of header word 2, counting from 0) leaves one lower than it arrived.
- R5: In every forwarded frame, the checksum field (bits 15:0 of header word 2) leaves equal to the incoming value plus 0x0100 with end-around carry.
- R6: A frame that passes R1 to R3 and R9 but carries a TTL of 0 or 1 produces no output words and exactly one single-cycle `icmp_req` pulse. A frame that fails R1 to R3 or R9 never raises `icmp_req`.
- R7: `out_sop` is high for exactly one cycle, on the output word whose index equals the header length; a frame with no payload words has no `out_sop`.
- R8: A forwarded frame leaves with every word other than word 2 unchanged and in order. `out_sof` is high on its first word and `out_eof` on its last, and `out_en` is high only on real words.
- R9: A frame whose end mark arrives before its header is complete produces no output words.
- R10: Input words with `in_en` low, and words with `in_en` high that arrive outside a frame (no preceding start strobe), are ignored.
- R11: While reset is held, `out_en`, `out_sof`, `out_eof`, `out_sop` and `icmp_req` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_data | input | 32 | Input data word |
| in_en | input | 1 | Input word valid |
| in_sof | input | 1 | First word of a frame |
| in_eof | input | 1 | Last word of a frame |
| out_data | output | 32 | Output data word |
| out_en | output | 1 | Output word valid |
| out_sof | output | 1 | First output word of a frame |
| out_eof | output | 1 | Last output word of a frame |
| out_sop | output | 1 | First payload word after the header |
| icmp_req | output | 1 | One-cycle pulse: TTL expired, reply needed |

## Verification
The forwarding path is swept over every legal header length from 5 to 15, with zero to three payload words and several TTL values. Frames are sent both back to back and with idle gaps. This separates a misplaced payload strobe, a wrong rewrite slot and FIFO ordering errors. Every version other than 4 and every header length from 0 to 4 are tried, and each header word is corrupted in turn. Frames are also cut off before the header ends. Each of these must vanish, which tells the individual drop conditions apart. Expiring TTLs of 0 and 1 are sent with good and bad checksums, which separates the ICMP indication from a silent drop.

// File: rtl/ipv4f_pkg.sv
package ipv4f_pkg;

    localparam int DW            = 32;
    localparam int IHL_W         = 4;
    localparam int HDR_MIN_WORDS = 5;
    localparam int HDR_MAX_WORDS = (1 << IHL_W) - 1;
    localparam int IP_VERSION    = 4;
    localparam int TTL_WORD      = 2;
    localparam int ACC_W         = 16 + $clog2(2 * HDR_MAX_WORDS);

    typedef enum logic [1:0] {
        ACT_FWD    = 2'd0,
        ACT_DROP   = 2'd1,
        ACT_EXPIRE = 2'd2
    } act_e;

    typedef struct packed {
        act_e             act;
        logic [IHL_W-1:0] ihl;
    } verdict_t;

    // Fold a wide one's-complement accumulator into 16 bits.
    function automatic logic [15:0] fold_sum(input logic [ACC_W-1:0] s);
        logic [16:0] a;
        a = {1'b0, s[15:0]} + 17'(s[ACC_W-1:16]);
        return a[15:0] + 16'(a[16]);
    endfunction

    // Checksum correction for a TTL decrement: add 0x0100, end-around carry.
    function automatic logic [15:0] bump_csum(input logic [15:0] c);
        logic [16:0] a;
        a = {1'b0, c} + 17'h00100;
        return a[15:0] + 16'(a[16]);
    endfunction

endpackage

// File: rtl/ipv4f_fifo.sv
module ipv4f_fifo #(
    parameter int W     = 33,
    parameter int DEPTH = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wp;
    logic [AW:0]  rp;

    assign empty = (wp == rp);
    assign full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
    assign dout  = mem[rp[AW-1:0]];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp <= '0;
            rp <= '0;
        end else begin
            if (push && !full) wp <= wp + 1'b1;
            if (pop && !empty) rp <= rp + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push && !full) mem[wp[AW-1:0]] <= din;
    end

endmodule

// File: rtl/ipv4f_hdr_scan.sv
module ipv4f_hdr_scan
    import ipv4f_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] in_data,
    input  logic          in_en,
    input  logic          in_sof,
    input  logic          in_eof,
    output logic          busy,
    output logic          vd_push,
    output verdict_t      vd
);
    typedef enum logic [1:0] {
        SC_IDLE = 2'd0,
        SC_HDR  = 2'd1,
        SC_BODY = 2'd2
    } scan_st_e;

    scan_st_e         st, st_n;
    logic [ACC_W-1:0] acc_q;
    logic [IHL_W-1:0] idx_q;
    logic [IHL_W-1:0] ihl_q;
    logic [7:0]       ttl_q;
    logic [ACC_W-1:0] hdr_sum;
    logic             hdr_bad_start;
    logic             sum_ok;

    assign busy          = (st != SC_IDLE);
    assign hdr_sum       = ((st == SC_IDLE) ? '0 : acc_q)
                           + ACC_W'(in_data[31:16]) + ACC_W'(in_data[15:0]);
    assign sum_ok        = (fold_sum(hdr_sum) == 16'hFFFF);
    assign hdr_bad_start = (in_data[31:28] != 4'(IP_VERSION))
                           || (in_data[27:24] < IHL_W'(HDR_MIN_WORDS));

    always_comb begin
        st_n    = st;
        vd_push = 1'b0;
        vd      = '{act: ACT_DROP, ihl: ihl_q};
        unique case (st)
            SC_IDLE: begin
                if (in_en && in_sof) begin
                    if (hdr_bad_start || in_eof) begin
                        vd_push = 1'b1;
                        st_n    = in_eof ? SC_IDLE : SC_BODY;
                    end else begin
                        st_n = SC_HDR;
                    end
                end
            end
            SC_HDR: begin
                if (in_en) begin
                    if (idx_q == ihl_q - 1'b1) begin
                        vd_push = 1'b1;
                        if (!sum_ok)            vd.act = ACT_DROP;
                        else if (ttl_q < 8'd2)  vd.act = ACT_EXPIRE;
                        else                    vd.act = ACT_FWD;
                        st_n = in_eof ? SC_IDLE : SC_BODY;
                    end else if (in_eof) begin
                        vd_push = 1'b1;
                        st_n    = SC_IDLE;
                    end
                end
            end
            SC_BODY: begin
                if (in_en && in_eof) st_n = SC_IDLE;
            end
            default: st_n = SC_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= SC_IDLE;
        else        st <= st_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            idx_q <= '0;
            ihl_q <= '0;
            ttl_q <= '0;
        end else if (in_en) begin
            if (st == SC_IDLE) begin
                acc_q <= hdr_sum;
                idx_q <= IHL_W'(1);
                ihl_q <= in_data[27:24];
            end else if (st == SC_HDR) begin
                acc_q <= hdr_sum;
                idx_q <= idx_q + 1'b1;
                if (idx_q == IHL_W'(TTL_WORD)) ttl_q <= in_data[31:24];
            end
        end
    end

endmodule

// File: rtl/ipv4_ttl_fwd.sv
module ipv4_ttl_fwd
    import ipv4f_pkg::*;
#(
    parameter int WORD_DEPTH    = 32,
    parameter int VERDICT_DEPTH = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [31:0]   in_data,
    input  logic          in_en,
    input  logic          in_sof,
    input  logic          in_eof,
    output logic [31:0]   out_data,
    output logic          out_en,
    output logic          out_sof,
    output logic          out_eof,
    output logic          out_sop,
    output logic          icmp_req
);
    localparam int WF_W = DW + 1;
    localparam int VF_W = $bits(verdict_t);
    localparam int WI_W = IHL_W + 1;

    typedef enum logic [1:0] {
        OS_WAIT = 2'd0,
        OS_FWD  = 2'd1,
        OS_DROP = 2'd2
    } out_st_e;

    // Input side
    logic           scan_busy;
    logic           vf_push, vf_full, vf_empty, vf_pop;
    verdict_t       vd_in;
    logic [VF_W-1:0] vf_dout;
    logic           wf_push, wf_full, wf_empty, wf_pop;
    logic [WF_W-1:0] wf_dout;

    ipv4f_hdr_scan u_scan (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_data (in_data),
        .in_en   (in_en),
        .in_sof  (in_sof),
        .in_eof  (in_eof),
        .busy    (scan_busy),
        .vd_push (vf_push),
        .vd      (vd_in)
    );

    assign wf_push = in_en && (scan_busy || in_sof);

    ipv4f_fifo #(.W(WF_W), .DEPTH(WORD_DEPTH)) u_word_q (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (wf_push),
        .din   ({in_eof, in_data}),
        .pop   (wf_pop),
        .dout  (wf_dout),
        .empty (wf_empty),
        .full  (wf_full)
    );

    ipv4f_fifo #(.W(VF_W), .DEPTH(VERDICT_DEPTH)) u_verdict_q (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (vf_push),
        .din   (vd_in),
        .pop   (vf_pop),
        .dout  (vf_dout),
        .empty (vf_empty),
        .full  (vf_full)
    );

    // Output side
    out_st_e          st, st_n;
    verdict_t         vhead;
    logic             head_eof;
    logic [DW-1:0]    head_data;
    logic             start;
    logic             emit;
    logic             ttl_slot;
    logic [DW-1:0]    rewritten;
    logic [IHL_W-1:0] ihl_q;
    logic [WI_W-1:0]  wi_q;

    assign vhead     = verdict_t'(vf_dout);
    assign head_eof  = wf_dout[DW];
    assign head_data = wf_dout[DW-1:0];
    assign start     = (st == OS_WAIT) && !wf_empty && !vf_empty;
    assign vf_pop    = start;
    assign wf_pop    = start || (((st == OS_FWD) || (st == OS_DROP)) && !wf_empty);
    assign emit      = (start && (vhead.act == ACT_FWD)) || ((st == OS_FWD) && !wf_empty);
    assign ttl_slot  = !start && (wi_q == WI_W'(TTL_WORD));
    assign rewritten = {head_data[31:24] - 8'd1, head_data[23:16], bump_csum(head_data[15:0])};

    always_comb begin
        st_n = st;
        unique case (st)
            OS_WAIT: begin
                if (start && !head_eof)
                    st_n = (vhead.act == ACT_FWD) ? OS_FWD : OS_DROP;
            end
            OS_FWD, OS_DROP: begin
                if (!wf_empty && head_eof) st_n = OS_WAIT;
            end
            default: st_n = OS_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= OS_WAIT;
        else        st <= st_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data <= '0;
            out_en   <= 1'b0;
            out_sof  <= 1'b0;
            out_eof  <= 1'b0;
            out_sop  <= 1'b0;
            icmp_req <= 1'b0;
            ihl_q    <= '0;
            wi_q     <= '0;
        end else begin
            out_en   <= emit;
            out_sof  <= emit && start;
            out_eof  <= emit && head_eof;
            out_sop  <= emit && !start && (wi_q == {1'b0, ihl_q});
            out_data <= !emit ? '0 : (ttl_slot ? rewritten : head_data);
            icmp_req <= start && (vhead.act == ACT_EXPIRE);
            if (start) begin
                ihl_q <= vhead.ihl;
                wi_q  <= WI_W'(1);
            end else if (emit && (wi_q != '1)) begin
                wi_q <= wi_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/ipv4_ttl_fwd_chk.sv
module ipv4_ttl_fwd_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] out_data,
    input logic        out_en,
    input logic        out_sof,
    input logic        out_eof,
    input logic        out_sop,
    input logic        icmp_req,
    input logic        wf_push,
    input logic        wf_full,
    input logic        vf_push,
    input logic        vf_full
);
    logic [4:0] ow_idx;

    always_ff @(posedge clk) begin
        if (!rst_n)                 ow_idx <= '0;
        else if (out_en && out_sof) ow_idx <= 5'd1;
        else if (out_en && ow_idx != 5'h1F) ow_idx <= ow_idx + 5'd1;
    end

    AST_RESET_QUIET:     assert property (@(posedge clk) !rst_n |=> (!out_en && !out_sof && !out_eof && !out_sop && !icmp_req)); // R11
    AST_VERSION_OUT:     assert property (@(posedge clk) disable iff (!rst_n) out_sof |-> (out_data[31:28] == 4'd4)); // R1
    AST_IHL_OUT:         assert property (@(posedge clk) disable iff (!rst_n) out_sof |-> (out_data[27:24] >= 4'd5)); // R2
    AST_TTL_OUT_LIVE:    assert property (@(posedge clk) disable iff (!rst_n) (out_en && !out_sof && ow_idx == 5'd2) |-> (out_data[31:24] != 8'd0)); // R4
    AST_ICMP_SINGLE:     assert property (@(posedge clk) disable iff (!rst_n) icmp_req |=> !icmp_req); // R6
    AST_ICMP_NO_START:   assert property (@(posedge clk) disable iff (!rst_n) icmp_req |-> !out_sof); // R6
    AST_SOP_SINGLE:      assert property (@(posedge clk) disable iff (!rst_n) out_sop |=> !out_sop); // R7
    AST_SOP_QUALIFIED:   assert property (@(posedge clk) disable iff (!rst_n) out_sop |-> (out_en && !out_sof)); // R7
    AST_SOF_QUALIFIED:   assert property (@(posedge clk) disable iff (!rst_n) (out_sof || out_eof) |-> out_en); // R8
    AST_WORDQ_NO_OVERFLOW:    assert property (@(posedge clk) disable iff (!rst_n) wf_push |-> !wf_full); // R8
    AST_VERDICTQ_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) vf_push |-> !vf_full); // R8

endmodule

bind ipv4_ttl_fwd ipv4_ttl_fwd_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .out_data (out_data),
    .out_en   (out_en),
    .out_sof  (out_sof),
    .out_eof  (out_eof),
    .out_sop  (out_sop),
    .icmp_req (icmp_req),
    .wf_push  (wf_push),
    .wf_full  (wf_full),
    .vf_push  (vf_push),
    .vf_full  (vf_full)
);

// File: tb/test_ipv4_ttl_fwd.sv
module test_ipv4_ttl_fwd;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_en = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic [31:0] out_data;
    logic        out_en, out_sof, out_eof, out_sop, icmp_req;

    always #10 clk = ~clk;

    ipv4_ttl_fwd i_ipv4_ttl_fwd (
        .clk(clk), .rst_n(rst_n),
        .in_data(in_data), .in_en(in_en), .in_sof(in_sof), .in_eof(in_eof),
        .out_data(out_data), .out_en(out_en), .out_sof(out_sof),
        .out_eof(out_eof), .out_sop(out_sop), .icmp_req(icmp_req)
    );

    int n_tests = 0, n_fail = 0;
    logic [31:0] exp_data [0:8191];
    logic [2:0]  exp_flg  [0:8191];
    string       exp_tag  [0:8191];
    int exp_wr = 0, exp_rd = 0;
    int icmp_exp = 0, icmp_seen = 0;
    string cur_tag = "R11";
    logic [31:0] seed = 32'h1234_5678;

    function automatic logic [31:0] rnd();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed;
    endfunction

    function automatic logic [15:0] hsum(input logic [31:0] a [0:19], input int n);
        int s = 0;
        for (int i = 0; i < n; i++) s += int'(a[i][31:16]) + int'(a[i][15:0]);
        while (s > 32'hFFFF) s = (s & 32'hFFFF) + (s >>> 16);
        return ~s[15:0];
    endfunction

    task automatic check(input bit ok, input string tag, input string what, input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    // Output monitor: every output word is compared in order
    always @(negedge clk) begin
        if (rst_n) begin
            if (icmp_req) icmp_seen++;
            if (out_en) begin
                n_tests++;
                if (exp_rd >= exp_wr) begin
                    n_fail++;
                    $display("FAIL %s unexpected word actual=%h expected=none", cur_tag, out_data);
                end else begin
                    if (out_data !== exp_data[exp_rd] || {out_sof, out_sop, out_eof} !== exp_flg[exp_rd]) begin
                        n_fail++;
                        $display("FAIL %s word %0d actual=%h/%b expected=%h/%b", exp_tag[exp_rd], exp_rd,
                                 out_data, {out_sof, out_sop, out_eof}, exp_data[exp_rd], exp_flg[exp_rd]);
                    end
                    exp_rd++;
                end
            end
        end
    end

    task automatic send_pkt(input int ver, input int ihl, input int ttl, input int npay,
                            input int bad, input int trunc, input bit gaps, input string tag);
        logic [31:0] w [0:19];
        int hlen, nw, c;
        bit ok_hdr;
        hlen = (ihl < 5) ? 5 : ihl;
        for (int i = 0; i < 20; i++) w[i] = rnd();
        w[0] = {4'(ver), 4'(ihl), 8'h00, 16'((hlen + npay) * 4)};
        w[2] = {8'(ttl), 8'd17, 16'h0000};
        w[2][15:0] = hsum(w, hlen);
        if (bad >= 0) w[bad] = w[bad] ^ 32'h0001_0000;
        nw = (trunc >= 0) ? trunc : hlen + npay;
        ok_hdr = (ver == 4) && (ihl >= 5) && (bad < 0) && (nw >= hlen);
        if (ok_hdr && ttl < 2) icmp_exp++;
        if (ok_hdr && ttl >= 2) begin
            for (int i = 0; i < nw; i++) begin
                if (i == 2) begin
                    c = int'(w[2][15:0]) + 256;
                    if (c > 32'hFFFF) c = (c & 32'hFFFF) + 1;
                    exp_data[exp_wr] = {w[2][31:24] - 8'd1, w[2][23:16], c[15:0]};
                    exp_tag[exp_wr]  = {tag, " R4/R5 ttl+csum"};
                end else begin
                    exp_data[exp_wr] = w[i];
                    exp_tag[exp_wr]  = (i == hlen) ? {tag, " R7 sop word"} : {tag, " R8 word"};
                end
                exp_flg[exp_wr] = {i == 0, i == hlen, i == nw - 1};
                exp_wr++;
            end
        end
        cur_tag = tag;
        for (int i = 0; i < nw; i++) begin
            if (gaps && (i % 3 == 1)) begin
                @(negedge clk);
                in_en = 1'b0; in_sof = 1'b1; in_eof = 1'b1; in_data = rnd();
            end
            @(negedge clk);
            in_en = 1'b1; in_data = w[i];
            in_sof = (i == 0); in_eof = (i == nw - 1);
        end
        @(negedge clk);
        in_en = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    endtask

    task automatic drain(input string tag);
        repeat (80) @(negedge clk);
        #1;
        check(exp_rd == exp_wr, tag, "output words", exp_rd, exp_wr);
        check(icmp_seen == icmp_exp, tag, "icmp pulses", icmp_seen, icmp_exp);
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R8 actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int ttls [4] = '{2, 3, 128, 255};
        // R11: reset state
        repeat (3) @(negedge clk);
        check({out_en, out_sof, out_eof, out_sop, icmp_req} == 5'b0, "R11", "outputs in reset",
              int'({out_en, out_sof, out_eof, out_sop, icmp_req}), 0);
        rst_n = 1'b1;
        // R10: stray words outside frames and disabled words
        cur_tag = "R10 stray words";
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            in_en = (i % 2 == 0); in_sof = (i % 2 == 1); in_eof = 1'b0; in_data = 32'h4500_0000;
        end
        @(negedge clk); in_en = 1'b0; in_sof = 1'b0;
        drain("R10");
        // R4 R5 R7 R8: forwarding sweep over header and payload lengths
        for (int h = 5; h <= 15; h++)
            for (int p = 0; p <= 3; p++)
                for (int t = 0; t < 4; t++) begin
                    send_pkt(4, h, ttls[t], p, -1, -1, bit'((h + p + t) % 2),
                             $sformatf("R8 fwd ihl=%0d pay=%0d ttl=%0d", h, p, ttls[t]));
                    if (t == 3) drain("R7 fwd sweep");
                end
        // R1: every wrong version
        for (int v = 0; v < 16; v++)
            if (v != 4) begin
                send_pkt(v, 5, 64, 2, -1, -1, 1'b0, $sformatf("R1 version=%0d", v));
                drain("R1");
            end
        // R2: short header lengths
        for (int h = 0; h < 5; h++) begin
            send_pkt(4, h, 64, 2, -1, -1, 1'b0, $sformatf("R2 ihl=%0d", h));
            drain("R2");
        end
        // R3: corrupt each header word in turn, with TTL 1 too (no icmp)
        for (int h = 5; h <= 15; h++) begin
            for (int b = 0; b < h; b++)
                send_pkt(4, h, (b % 2 == 0) ? 64 : 1, 1, b, -1, bit'(b % 2),
                         $sformatf("R3 ihl=%0d bad word %0d", h, b));
            drain("R3 bad checksum / R6 no icmp");
        end
        // R6: expiring TTL values
        for (int h = 5; h <= 15; h += 5)
            for (int p = 0; p <= 2; p++)
                for (int t = 0; t < 2; t++) begin
                    send_pkt(4, h, t, p, -1, -1, 1'b0, $sformatf("R6 ihl=%0d ttl=%0d", h, t));
                    drain("R6 icmp");
                end
        // R9: frames ending inside the header
        for (int h = 5; h <= 8; h++)
            for (int n = 1; n < h; n++) begin
                send_pkt(4, h, 64, 2, -1, n, 1'b0, $sformatf("R9 ihl=%0d words=%0d", h, n));
                drain("R9");
            end
        // back-to-back forwarding after the drop cases
        for (int h = 5; h <= 15; h++)
            send_pkt(4, h, 2, 3, -1, -1, 1'b0, $sformatf("R8 burst ihl=%0d", h));
        drain("R8 burst");
        finish_run();
    end

endmodule